// File: doc/BRIEF.md
# Handshaked PHY Delay Register Port

This block places a bank of 8-bit PHY delay registers behind one 32-bit host register. The host never reaches a PHY register directly. It loads a target index and a data byte into fields of the port word, then sets a write strobe or a read strobe. The port captures the request on the first clock edge where it sees a strobe. After a fixed number of cycles it performs the access and sets an acknowledge flag.

The host polls for acknowledge and then clears its strobe. The port drops acknowledge on the first edge that sees both strobes low, which closes a four-phase handshake. Read results come back in a read-only byte field of the same word. The delay values are also driven out of the block continuously, so the PHY can use them.

Top module: `phy_dly_port`

## Requirements
- R1: After reset the port word reads 0x00000000, acknowledge is low and every delay output is zero.
- R2: A host write sets the PHY index from bits 5:0, the write data from bits 15:8, the write strobe from bit 24 and the read strobe from bit 25. Bits 23:16 (read data) and bit 26 (acknowledge) cannot be changed by the host. Bits 31:27 and 7:6 always read as zero.
- R3: A write access stores the write-data byte in the selected PHY register. Acknowledge (bit 26) rises exactly ACK_LAT clock edges after the first edge that sees the strobe high, and the stored value appears at the same edge.
- R4: Acknowledge stays high for as long as either strobe is high, and each handshake performs exactly one access. Acknowledge falls on the first edge that sees both strobes low, and only after that can a new access start.
- R5: A read access loads the selected register into bits 23:16 no later than the edge where acknowledge rises. That field then holds its value until the next read completes.
- R6: When both strobes are set together, the access is a write. The read-data field is left unchanged.
- R7: Index and data are captured on the edge that starts the access. Changing those fields while a strobe is high has no effect on that access.
- R8: Only indices 0x00–0x08 and 0x0B–0x0D are implemented. An access to any other index still acknowledges, returns zero on read and discards the write.
- R9: Each implemented register holds a full 8-bit value and keeps it until it is written again. A write changes only the register it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe for the port word |
| bus_wdata | input | 32 | Host write value |
| bus_rdata | output | 32 | Current port word |
| dly_taps | output | TAP_CNT*8 | Delay register values, index 0 in the low byte; unimplemented indices read zero |

## Verification
The assertions assume the host follows the handshake. Once a strobe is raised, the host keeps it high until it sees acknowledge, and it lowers both strobes before starting another access. The hold and drop checks on acknowledge only hold under that discipline. The directed tasks keep to it. The only deliberate exceptions are rewriting the index and data fields while a strobe stays high, and holding the strobe high long after acknowledge, and both exceptions stay within the protocol.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
    localparam int unsigned IDX_W   = 6;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WORD_W  = 32;
    // field positions in the port word
    localparam int unsigned POS_IDX  = 0;
    localparam int unsigned POS_WDAT = 8;
    localparam int unsigned POS_RDAT = 16;
    localparam int unsigned POS_WSTB = 24;
    localparam int unsigned POS_RSTB = 25;
    localparam int unsigned POS_ACK  = 26;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_DONE = 2'd2
    } hs_state_e;

    function automatic logic idx_present(input int unsigned idx);
        return (idx <= 8) || ((idx >= 11) && (idx <= 13));
    endfunction
endpackage

// File: rtl/phy_port_hs.sv
module phy_port_hs
    import phy_port_pkg::*;
#(
    parameter int unsigned ACK_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wstb_i,
    input  logic              rstb_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BYTE_W-1:0] wdat_i,
    output logic              ack_o,
    output logic              bank_we_o,
    output logic              rd_load_o,
    output logic [IDX_W-1:0]  bank_idx_o,
    output logic [BYTE_W-1:0] bank_wdat_o
);
    localparam int unsigned CNT_W = $clog2(ACK_LAT + 1);

    typedef struct packed {
        hs_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic              is_wr;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] wdat;
        logic              ack;
    } hs_t;

    hs_t hs_d, hs_q;
    logic fire;

    always_comb begin
        hs_d = hs_q;
        fire = 1'b0;
        case (hs_q.state)
            HS_IDLE: begin
                if (wstb_i || rstb_i) begin
                    hs_d.state = HS_WAIT;
                    hs_d.cnt   = CNT_W'(1);
                    hs_d.is_wr = wstb_i;
                    hs_d.idx   = idx_i;
                    hs_d.wdat  = wdat_i;
                end
            end
            HS_WAIT: begin
                if (hs_q.cnt == CNT_W'(ACK_LAT)) begin
                    fire       = 1'b1;
                    hs_d.state = HS_DONE;
                    hs_d.ack   = 1'b1;
                end else begin
                    hs_d.cnt = hs_q.cnt + CNT_W'(1);
                end
            end
            HS_DONE: begin
                if (!wstb_i && !rstb_i) begin
                    hs_d.state = HS_IDLE;
                    hs_d.ack   = 1'b0;
                end
            end
            default: hs_d.state = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '{state: HS_IDLE, default: '0};
        end else begin
            hs_q <= hs_d;
        end
    end

    assign ack_o       = hs_q.ack;
    assign bank_we_o   = fire && hs_q.is_wr;
    assign rd_load_o   = fire && !hs_q.is_wr;
    assign bank_idx_o  = hs_q.idx;
    assign bank_wdat_o = hs_q.wdat;

    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && (wstb_i || rstb_i)) |=> ack_o);
    // R4
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !wstb_i && !rstb_i) |=> !ack_o);
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q.cnt <= CNT_W'(ACK_LAT));
    // R6
    both_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q.state == HS_IDLE && wstb_i && rstb_i) |=> hs_q.is_wr);
endmodule

// File: rtl/phy_delay_bank.sv
module phy_delay_bank
    import phy_port_pkg::*;
#(
    parameter int unsigned TAP_CNT = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [BYTE_W-1:0]         wdat_i,
    output logic [BYTE_W-1:0]         rdat_o,
    output logic [TAP_CNT*BYTE_W-1:0] taps_o
);
    localparam int unsigned SLOTS = 1 << IDX_W;

    logic [SLOTS-1:0][BYTE_W-1:0] cells;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (idx_present(g)) begin : g_reg
            logic [BYTE_W-1:0] cell_d, cell_q;
            always_comb begin
                cell_d = cell_q;
                if (we_i && (idx_i == IDX_W'(g))) cell_d = wdat_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cell_q <= '0;
                else        cell_q <= cell_d;
            end
            assign cells[g] = cell_q;
        end else begin : g_hole
            assign cells[g] = '0;
        end
    end

    assign rdat_o = cells[idx_i];
    assign taps_o = cells[TAP_CNT-1:0];

    // R9
    one_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cells));
endmodule

// File: rtl/phy_dly_port.sv
module phy_dly_port
    import phy_port_pkg::*;
#(
    parameter int unsigned ACK_LAT = 3,
    parameter int unsigned TAP_CNT = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic [TAP_CNT*8-1:0]      dly_taps
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] wdat;
        logic [BYTE_W-1:0] rdat;
        logic              wstb;
        logic              rstb;
    } port_t;

    port_t pt_d, pt_q;
    logic              ack, bank_we, rd_load;
    logic [IDX_W-1:0]  bank_idx;
    logic [BYTE_W-1:0] bank_wdat, bank_rdat;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[31:27], bus_wdata[23:16], bus_wdata[7:6]};

    always_comb begin
        pt_d = pt_q;
        if (bus_wr) begin
            pt_d.idx  = bus_wdata[POS_IDX  +: IDX_W];
            pt_d.wdat = bus_wdata[POS_WDAT +: BYTE_W];
            pt_d.wstb = bus_wdata[POS_WSTB];
            pt_d.rstb = bus_wdata[POS_RSTB];
        end
        if (rd_load) pt_d.rdat = bank_rdat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    always_comb begin
        bus_rdata = '0;
        bus_rdata[POS_IDX  +: IDX_W]  = pt_q.idx;
        bus_rdata[POS_WDAT +: BYTE_W] = pt_q.wdat;
        bus_rdata[POS_RDAT +: BYTE_W] = pt_q.rdat;
        bus_rdata[POS_WSTB]           = pt_q.wstb;
        bus_rdata[POS_RSTB]           = pt_q.rstb;
        bus_rdata[POS_ACK]            = ack;
    end

    phy_port_hs #(.ACK_LAT(ACK_LAT)) u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wstb_i      (pt_q.wstb),
        .rstb_i      (pt_q.rstb),
        .idx_i       (pt_q.idx),
        .wdat_i      (pt_q.wdat),
        .ack_o       (ack),
        .bank_we_o   (bank_we),
        .rd_load_o   (rd_load),
        .bank_idx_o  (bank_idx),
        .bank_wdat_o (bank_wdat)
    );

    phy_delay_bank #(.TAP_CNT(TAP_CNT)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (bank_we),
        .idx_i  (bank_idx),
        .wdat_i (bank_wdat),
        .rdat_o (bank_rdat),
        .taps_o (dly_taps)
    );

    // R5
    rdat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> $stable(pt_q.rdat));
    // R3
    we_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> ack);
    // R4
    single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_we || rd_load) |=> !(bank_we || rd_load));
endmodule

// File: tb/tb_phy_dly_port.sv
module tb_phy_dly_port;
    localparam int unsigned LAT = 3;
    localparam int unsigned TAPS = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [TAPS*8-1:0] dly_taps;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    phy_dly_port #(.ACK_LAT(LAT), .TAP_CNT(TAPS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dly_taps(dly_taps));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic wr, input logic rd,
                                         input logic [5:0] idx, input logic [7:0] dat);
        return {5'b0, 1'b0, rd, wr, 8'h00, dat, 2'b00, idx};
    endfunction

    function automatic logic [7:0] tap(input int i);
        return dly_taps[i*8 +: 8];
    endfunction

    task automatic bus_put(input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_ack(input logic lvl, input string tag);
        int k = 0;
        while (bus_rdata[26] !== lvl && k < 40) begin
            @(negedge clk);
            k++;
        end
        check(tag, {31'b0, bus_rdata[26]}, {31'b0, lvl});
    endtask

    // full handshake with exact acknowledge timing
    task automatic access(input logic wr, input logic rd, input logic [5:0] idx,
                          input logic [7:0] dat, input string tag);
        bus_put(word(1'b0, 1'b0, idx, dat));
        bus_put(word(wr, rd, idx, dat));
        repeat (LAT) @(negedge clk);
        check({tag, " ack early"}, {31'b0, bus_rdata[26]}, 32'd0);
        @(negedge clk);
        check({tag, " ack on time"}, {31'b0, bus_rdata[26]}, 32'd1);
        bus_put(word(1'b0, 1'b0, idx, dat));
        check({tag, " ack held until seen low"}, {31'b0, bus_rdata[26]}, 32'd1);
        @(negedge clk);
        check({tag, " ack dropped"}, {31'b0, bus_rdata[26]}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 port word", bus_rdata, 32'h0);
        for (int i = 0; i < TAPS; i++) check("R1 tap", {24'b0, tap(i)}, 32'h0);
    endtask

    task automatic t_fields();
        bus_put(32'hF8FF_FFFF);
        check("R2 field readback", bus_rdata, 32'h0000_FF3F);
        bus_put(32'h0);
        check("R2 cleared", bus_rdata, 32'h0);
    endtask

    task automatic t_write();
        access(1'b1, 1'b0, 6'h02, 8'h5A, "R3 write");
        check("R3 tap2", {24'b0, tap(2)}, 32'h5A);
    endtask

    task automatic t_read();
        access(1'b0, 1'b1, 6'h02, 8'h00, "R5 read");
        check("R5 rdata", {24'b0, bus_rdata[23:16]}, 32'h5A);
        repeat (5) @(negedge clk);
        check("R5 rdata held", {24'b0, bus_rdata[23:16]}, 32'h5A);
    endtask

    task automatic t_both();
        access(1'b1, 1'b1, 6'h03, 8'h77, "R6 both strobes");
        check("R6 tap3 written", {24'b0, tap(3)}, 32'h77);
        check("R6 rdata untouched", {24'b0, bus_rdata[23:16]}, 32'h5A);
    endtask

    task automatic t_change();
        bus_put(word(1'b0, 1'b0, 6'h04, 8'h11));
        bus_put(word(1'b1, 1'b0, 6'h04, 8'h11));
        bus_put(word(1'b1, 1'b0, 6'h05, 8'h22));
        wait_ack(1'b1, "R7 ack");
        bus_put(word(1'b0, 1'b0, 6'h05, 8'h22));
        wait_ack(1'b0, "R7 ack low");
        check("R7 tap4 captured", {24'b0, tap(4)}, 32'h11);
        check("R7 tap5 untouched", {24'b0, tap(5)}, 32'h0);
    endtask

    task automatic t_hold();
        bus_put(word(1'b0, 1'b0, 6'h06, 8'h01));
        bus_put(word(1'b1, 1'b0, 6'h06, 8'h01));
        wait_ack(1'b1, "R4 ack");
        bus_put(word(1'b1, 1'b0, 6'h06, 8'h02));
        repeat (10) @(negedge clk);
        check("R4 ack stays high", {31'b0, bus_rdata[26]}, 32'd1);
        check("R4 one access only", {24'b0, tap(6)}, 32'h01);
        bus_put(word(1'b0, 1'b0, 6'h06, 8'h02));
        wait_ack(1'b0, "R4 ack low");
        repeat (5) @(negedge clk);
        check("R4 no new access", {24'b0, tap(6)}, 32'h01);
    endtask

    task automatic t_holes();
        access(1'b1, 1'b0, 6'h09, 8'hAB, "R8 write idx 9");
        check("R8 tap9 zero", {24'b0, tap(9)}, 32'h0);
        access(1'b1, 1'b0, 6'h3F, 8'hCD, "R8 write idx 3F");
        access(1'b0, 1'b1, 6'h3F, 8'h00, "R8 read idx 3F");
        check("R8 read 3F zero", {24'b0, bus_rdata[23:16]}, 32'h0);
        access(1'b0, 1'b1, 6'h0A, 8'h00, "R8 read idx A");
        check("R8 read A zero", {24'b0, bus_rdata[23:16]}, 32'h0);
    endtask

    task automatic t_edges();
        access(1'b1, 1'b0, 6'h0D, 8'hC3, "R9 write D");
        access(1'b1, 1'b0, 6'h00, 8'hFF, "R9 write 0");
        access(1'b1, 1'b0, 6'h08, 8'h80, "R9 write 8");
        access(1'b1, 1'b0, 6'h0B, 8'h01, "R9 write B");
        check("R9 tap13", {24'b0, tap(13)}, 32'hC3);
        check("R9 tap0", {24'b0, tap(0)}, 32'hFF);
        check("R9 tap8", {24'b0, tap(8)}, 32'h80);
        check("R9 tap11", {24'b0, tap(11)}, 32'h01);
        check("R9 tap12 untouched", {24'b0, tap(12)}, 32'h0);
        check("R9 tap2 kept", {24'b0, tap(2)}, 32'h5A);
        access(1'b0, 1'b1, 6'h0D, 8'h00, "R9 read D");
        check("R9 read D", {24'b0, bus_rdata[23:16]}, 32'hC3);
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_write();
        t_read();
        t_both();
        t_change();
        t_hold();
        t_holes();
        t_edges();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule